// File: doc/BRIEF.md
# Transmit Clock Activity Mode Monitor

This block watches the transmit clock of every line channel and decides how that channel's transmitter behaves. The three possible states are normal data, a continuous all-ones pattern, and powered down. It measures how long each transmit clock has stayed at one level. The unit of that measurement is a reference clock. The master clock is the reference while it runs. When the master clock stops, the transmit clock of one designated backup channel becomes the reference. If neither clock is running, every channel is forced to high impedance.

The whole block runs on a free-running local oscillator `clk`. The master clock and every transmit clock are synchronized into that domain, and their edges are detected there. The master clock counts as lost when no master-clock edge arrives within `LOSS_WIN` oscillator cycles. The backup reference is judged by the same rule.

Per channel, the block produces a 2-bit mode code and a registered driver enable. The driver enable combines the global output-enable input, a per-channel disable bit and the channel mode. The block also produces an alternating mark pattern that carries the all-ones signal. One mark is emitted per reference cycle.

Top module: `tx_clk_mode_mon`

## Requirements
- R1: While `rst` is high, every mode code reads 0, every driver enable reads 0, and both all-ones mark outputs read 0.
- R2: A channel whose transmit clock keeps toggling while a reference runs has mode code 0 (normal). Its driver enable is 1 when `oe` is 1 and its disable bit is 0. Channel i's code sits at `mode_o[2i+1:2i]`.
- R3: A channel whose transmit clock stays high for 16 or more reference rising edges gets mode code 1 (all-ones), and its driver stays enabled. A high run clearly shorter than 16 edges leaves the code at 0.
- R4: A channel whose transmit clock stays low for 64 or more reference rising edges gets mode code 2 (power-down), and its driver enable goes to 0. A low run of 40 edges leaves the code at 0 and never gives code 1.
- R5: A single observed transmit-clock edge returns a channel from all-ones or power-down to code 0 within a few oscillator cycles.
- R6: When no master-clock edge is seen for `LOSS_WIN` (8) oscillator cycles, the rising edges of channel `REF_CH` (1) become the reference. The 16 and 64 edge thresholds and the mark rate then follow that clock.
- R7: When neither the master clock nor channel `REF_CH`'s transmit clock has had an edge for `LOSS_WIN` oscillator cycles, every channel reads code 3 (high impedance) and every driver enable reads 0.
- R8: A low `oe` clears every driver enable. A 1 in `out_dis[i]` clears only `drv_en_o[i]`. Neither input changes any mode code.
- R9: Each reference rising edge gives exactly one single-cycle mark, on `ones_p_o` and `ones_n_o` in turn. The two marks are never high together, and no marks appear while no reference runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running local oscillator; all logic is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mclk | input | 1 | Master clock, asynchronous to `clk` |
| tclk | input | NCH | Transmit clock of each channel, asynchronous to `clk` |
| oe | input | 1 | Global output enable, active high |
| out_dis | input | NCH | Per-channel output disable bits, 1 disables |
| mode_o | output | 2*NCH | Mode code per channel: 0 normal, 1 all-ones, 2 power-down, 3 high impedance |
| drv_en_o | output | NCH | Per-channel line driver enable |
| ones_p_o | output | 1 | Positive all-ones mark, one oscillator cycle wide |
| ones_n_o | output | 1 | Negative all-ones mark, one oscillator cycle wide |

## Verification
The assertions assume that each supervised clock has a half period of at least two oscillator cycles. If a clock were faster, the synchronizer could miss edges, and the edge-based properties about returning to normal and about loss of reference would no longer follow.

The bench keeps the master clock at two oscillator cycles per half period and every transmit clock at four. Stuck clocks are produced only by holding a level. The bench therefore never breaks this assumption.

Threshold checks are sampled several reference cycles away from 16 and 64. This margin absorbs the synchronizer latency and the unknown phase of the last edge.

// File: rtl/txmon_pkg.sv
package txmon_pkg;
  typedef enum logic [1:0] {
    TXM_NORMAL = 2'd0,
    TXM_ONES   = 2'd1,
    TXM_PDOWN  = 2'd2,
    TXM_HIZ    = 2'd3
  } txm_mode_e;
endpackage

// File: rtl/txm_edge_sync.sv
module txm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic toggle
);
  // STAGES flops of synchronizer plus one history flop for edge detection
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign lvl    = sh[STAGES-1];
  assign rise   = sh[STAGES-1] & ~sh[STAGES];
  assign toggle = sh[STAGES-1] ^ sh[STAGES];
endmodule

// File: rtl/txm_ref_select.sv
module txm_ref_select #(
  parameter int LOSS_WIN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic mclk_tog,
  input  logic mclk_rise,
  input  logic bk_tog,
  input  logic bk_rise,
  output logic ref_tick,
  output logic ref_ok
);
  localparam int GW = $clog2(LOSS_WIN + 1);
  localparam logic [GW-1:0] WIN = GW'(LOSS_WIN);

  // Oscillator cycles since the last master and backup clock edges
  logic [GW-1:0] m_gap, b_gap;
  logic m_ok, b_ok;

  assign m_ok = (m_gap < WIN);
  assign b_ok = (b_gap < WIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_gap    <= '0;
      b_gap    <= '0;
      ref_tick <= 1'b0;
      ref_ok   <= 1'b1;
    end else begin
      if (mclk_tog)        m_gap <= '0;
      else if (m_gap != WIN) m_gap <= m_gap + 1'b1;
      if (bk_tog)          b_gap <= '0;
      else if (b_gap != WIN) b_gap <= b_gap + 1'b1;
      ref_tick <= m_ok ? mclk_rise : (b_ok & bk_rise);
      ref_ok   <= m_ok | b_ok;
    end
  end

  AST_BOTH_LOST_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (m_gap == WIN && b_gap == WIN) |=> !ref_ok); // R7
  AST_GAP_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (m_gap <= WIN) && (b_gap <= WIN)); // R6
endmodule

// File: rtl/txm_chan_mon.sv
module txm_chan_mon
  import txmon_pkg::*;
#(
  parameter int HI_LIM = 16,
  parameter int LO_LIM = 64
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl,
  input  logic      tog,
  input  logic      ref_tick,
  input  logic      ref_ok,
  output txm_mode_e mode
);
  localparam int CMAX = (LO_LIM > HI_LIM) ? LO_LIM : HI_LIM;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] HI_T = CW'(HI_LIM);
  localparam logic [CW-1:0] LO_T = CW'(LO_LIM);
  localparam logic [CW-1:0] SAT  = CW'(CMAX);

  // Reference edges seen since the last transmit-clock edge
  logic [CW-1:0] run;
  txm_mode_e     mode_nx;

  always_comb begin
    if (!ref_ok)                  mode_nx = TXM_HIZ;
    else if (tog)                 mode_nx = TXM_NORMAL;
    else if (!lvl && run >= LO_T) mode_nx = TXM_PDOWN;
    else if (lvl && run >= HI_T)  mode_nx = TXM_ONES;
    else                          mode_nx = TXM_NORMAL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= '0;
      mode <= TXM_NORMAL;
    end else begin
      if (tog)                        run <= '0;
      else if (ref_tick && run != SAT) run <= run + 1'b1;
      mode <= mode_nx;
    end
  end

  AST_EDGE_RESUMES: assert property (@(posedge clk) disable iff (rst)
    (tog && ref_ok) |=> mode == TXM_NORMAL); // R5
  AST_LOST_HIZ: assert property (@(posedge clk) disable iff (rst)
    !ref_ok |=> mode == TXM_HIZ); // R7
  AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (rst)
    run <= SAT); // R4
endmodule

// File: rtl/tx_clk_mode_mon.sv
module tx_clk_mode_mon
  import txmon_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int REF_CH      = 1,
  parameter int HI_LIM      = 16,
  parameter int LO_LIM      = 64,
  parameter int LOSS_WIN    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mclk,
  input  logic [NCH-1:0]   tclk,
  input  logic             oe,
  input  logic [NCH-1:0]   out_dis,
  output logic [2*NCH-1:0] mode_o,
  output logic [NCH-1:0]   drv_en_o,
  output logic             ones_p_o,
  output logic             ones_n_o
);
  logic           m_lvl, m_rise, m_tog;
  logic [NCH-1:0] t_lvl, t_rise, t_tog;
  logic           ref_tick, ref_ok;
  logic           pol;
  txm_mode_e      mode [NCH];

  txm_edge_sync #(.STAGES(SYNC_STAGES)) u_msync (
    .clk(clk), .rst(rst), .din(mclk),
    .lvl(m_lvl), .rise(m_rise), .toggle(m_tog)
  );

  txm_ref_select #(.LOSS_WIN(LOSS_WIN)) u_ref (
    .clk(clk), .rst(rst),
    .mclk_tog(m_tog), .mclk_rise(m_rise),
    .bk_tog(t_tog[REF_CH]), .bk_rise(t_rise[REF_CH]),
    .ref_tick(ref_tick), .ref_ok(ref_ok)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    txm_edge_sync #(.STAGES(SYNC_STAGES)) u_tsync (
      .clk(clk), .rst(rst), .din(tclk[i]),
      .lvl(t_lvl[i]), .rise(t_rise[i]), .toggle(t_tog[i])
    );

    txm_chan_mon #(.HI_LIM(HI_LIM), .LO_LIM(LO_LIM)) u_mon (
      .clk(clk), .rst(rst), .lvl(t_lvl[i]), .tog(t_tog[i]),
      .ref_tick(ref_tick), .ref_ok(ref_ok), .mode(mode[i])
    );

    assign mode_o[2*i +: 2] = mode[i];

    always_ff @(posedge clk) begin
      if (rst) drv_en_o[i] <= 1'b0;
      else     drv_en_o[i] <= oe & ~out_dis[i] &
                              ((mode[i] == TXM_NORMAL) || (mode[i] == TXM_ONES));
    end

    AST_PDOWN_OFF: assert property (@(posedge clk) disable iff (rst)
      (mode[i] == TXM_PDOWN || mode[i] == TXM_HIZ) |=> !drv_en_o[i]); // R4
  end

  // Alternating all-ones marks, one per reference rising edge
  always_ff @(posedge clk) begin
    if (rst) begin
      pol      <= 1'b0;
      ones_p_o <= 1'b0;
      ones_n_o <= 1'b0;
    end else begin
      ones_p_o <= ref_tick & ~pol;
      ones_n_o <= ref_tick & pol;
      if (ref_tick) pol <= ~pol;
    end
  end

  AST_MARKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ones_p_o, ones_n_o})); // R9
  AST_OE_GATES_ALL: assert property (@(posedge clk) disable iff (rst)
    !oe |=> drv_en_o == '0); // R8
endmodule

// File: tb/tb_tx_clk_mode_mon.sv
module tb_tx_clk_mode_mon;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mph = 1'b0, tph = 1'b0;
  logic mclk_run = 1'b1, mclk_lvl = 1'b0;
  logic [NCH-1:0] tclk_run = '1, tclk_lvl = '0;
  logic mclk;
  logic [NCH-1:0] tclk;
  logic oe = 1'b1;
  logic [NCH-1:0] out_dis = '0;
  logic [2*NCH-1:0] mode_o;
  logic [NCH-1:0] drv_en_o;
  logic ones_p_o, ones_n_o;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;    // 250 MHz oscillator
  always #8 mph = ~mph;    // master clock: 4 oscillator cycles per period
  always #16 tph = ~tph;   // transmit clocks: 8 oscillator cycles per period

  assign mclk = mclk_run ? mph : mclk_lvl;
  assign tclk = (tclk_run & {NCH{tph}}) | (~tclk_run & tclk_lvl);

  tx_clk_mode_mon dut (
    .clk(clk), .rst(rst), .mclk(mclk), .tclk(tclk), .oe(oe),
    .out_dis(out_dis), .mode_o(mode_o), .drv_en_o(drv_en_o),
    .ones_p_o(ones_p_o), .ones_n_o(ones_n_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_osc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] ch_mode(input int ch);
    return mode_o[2*ch +: 2];
  endfunction

  // Counts marks over n oscillator cycles; flags any cycle with both marks high
  task automatic count_marks(input int n, output int p, output int q, output int both);
    p = 0; q = 0; both = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (ones_p_o) p++;
      if (ones_n_o) q++;
      if (ones_p_o && ones_n_o) both++;
    end
  endtask

  task automatic t_reset;
    wait_osc(5);
    check(mode_o == '0, "R1 modes in reset", mode_o, 0);
    check(drv_en_o == '0, "R1 drv_en in reset", drv_en_o, 0);
    check({ones_p_o, ones_n_o} == 2'b00, "R1 marks in reset", {ones_p_o, ones_n_o}, 0);
    rst = 1'b0;
  endtask

  task automatic t_normal;
    wait_osc(30);
    check(mode_o == '0, "R2 all normal", mode_o, 0);
    check(drv_en_o == '1, "R2 all drivers on", drv_en_o, 8'hFF);
  endtask

  task automatic t_stuck_high;
    tclk_lvl[3] = 1'b1; tclk_run[3] = 1'b0;
    wait_osc(10 * 4);
    check(ch_mode(3) == 2'd0, "R3 short high run stays normal", ch_mode(3), 0);
    wait_osc(12 * 4);
    check(ch_mode(3) == 2'd1, "R3 high run gives all-ones", ch_mode(3), 1);
    check(drv_en_o[3] == 1'b1, "R3 driver on in all-ones", drv_en_o[3], 1);
    tclk_run[3] = 1'b1;
    wait_osc(12);
    check(ch_mode(3) == 2'd0, "R5 resume from all-ones", ch_mode(3), 0);
  endtask

  task automatic t_stuck_low;
    tclk_lvl[5] = 1'b0; tclk_run[5] = 1'b0;
    wait_osc(40 * 4);
    check(ch_mode(5) == 2'd0, "R4 low run of 40 stays normal", ch_mode(5), 0);
    wait_osc(40 * 4);
    check(ch_mode(5) == 2'd2, "R4 low run gives power-down", ch_mode(5), 2);
    check(drv_en_o[5] == 1'b0, "R4 driver off in power-down", drv_en_o[5], 0);
    tclk_run[5] = 1'b1;
    wait_osc(12);
    check(ch_mode(5) == 2'd0, "R5 resume from power-down", ch_mode(5), 0);
    wait_osc(2);
    check(drv_en_o[5] == 1'b1, "R5 driver back on", drv_en_o[5], 1);
  endtask

  task automatic t_enables;
    oe = 1'b0;
    wait_osc(3);
    check(drv_en_o == '0, "R8 global enable low", drv_en_o, 0);
    check(mode_o == '0, "R8 modes untouched by oe", mode_o, 0);
    oe = 1'b1; out_dis = 8'h04;
    wait_osc(3);
    check(drv_en_o == 8'hFB, "R8 per-channel disable", drv_en_o, 8'hFB);
    check(ch_mode(2) == 2'd0, "R8 mode untouched by disable", ch_mode(2), 0);
    out_dis = '0;
    wait_osc(3);
  endtask

  task automatic t_marks_master;
    int p, q, b;
    count_marks(400, p, q, b);
    check(p + q >= 98 && p + q <= 102, "R9 one mark per master edge", p + q, 100);
    check(p - q <= 1 && q - p <= 1, "R9 marks alternate", p - q, 0);
    check(b == 0, "R9 marks never together", b, 0);
  endtask

  task automatic t_master_loss;
    int p, q, b;
    mclk_run = 1'b0; mclk_lvl = 1'b1;
    wait_osc(20);
    check(mode_o == '0, "R6 backup reference keeps normal", mode_o, 0);
    count_marks(320, p, q, b);
    check(p + q >= 38 && p + q <= 42, "R6 marks follow backup clock", p + q, 40);
    tclk_lvl[3] = 1'b1; tclk_run[3] = 1'b0;
    wait_osc(10 * 8);
    check(ch_mode(3) == 2'd0, "R6 short high run on backup ref", ch_mode(3), 0);
    wait_osc(12 * 8);
    check(ch_mode(3) == 2'd1, "R6 all-ones counted on backup ref", ch_mode(3), 1);
  endtask

  task automatic t_both_lost;
    int p, q, b;
    tclk_lvl[1] = 1'b0; tclk_run[1] = 1'b0;
    wait_osc(20);
    check(mode_o == '1, "R7 all high impedance", mode_o, 16'hFFFF);
    check(drv_en_o == '0, "R7 all drivers off", drv_en_o, 0);
    count_marks(40, p, q, b);
    check(p + q == 0, "R9 no marks without reference", p + q, 0);
    tclk_run = '1; mclk_run = 1'b1;
    wait_osc(20);
    check(mode_o == '0, "R2 normal after references return", mode_o, 0);
    check(drv_en_o == '1, "R2 drivers on after return", drv_en_o, 8'hFF);
  endtask

  initial begin
    #200000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_stuck_high();
    t_stuck_low();
    t_enables();
    t_marks_master();
    t_master_loss();
    t_both_lost();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule